// File: doc/BRIEF.md
# Vector Instruction Decode and Branch Unit

This block takes one instruction word of a small vector-processing core and splits it into its fields: a 16-bit opcode, a destination address, and then either two source register addresses or a 32-bit immediate. The form depends on the opcode. For conditional jump opcodes the block also compares one chosen component of two 96-bit, three-component operands and produces a taken flag. It then selects the next program counter, which is the jump target on a taken jump and the following word otherwise.

The opcode alone controls branching. Bit 6 marks an immediate-form word. Bits 4:3 pick the vector component. Bits 2:0 pick the relation. Opcodes outside the recognised set are flagged and handled as no-operations. All outputs are registered, so results appear one clock after the word is presented.

Top module: `vdb_decode_branch`

## Requirements
- R1: While `rst` is high at a rising clock edge, every output is cleared to zero on that edge.
- R2: The opcode is `instr[63:48]` and the destination is `instr[47:32]`. For a legal word with opcode bit 6 clear, source 1 is `instr[31:16]`, source 2 is `instr[15:0]`, and `imm_out` is 0. For a legal word with bit 6 set, `imm_out` is `instr[31:0]` and both source outputs are 0. Source outputs are 0 for illegal words too.
- R3: `is_imm` is 1 exactly when the opcode is legal and opcode bit 6 is 1. This covers `0x40` (return), `0x41`..`0x44`, and `0x58`.
- R4: A conditional jump is an opcode with bits 15:5 zero, bits 4:3 nonzero and bits 2:0 at most `101`. Bits 4:3 select the component: `01` is X in `src_a/b[31:0]`, `10` is Y in bits 63:32, and `11` is Z in bits 95:64. `is_jump` reports conditional jumps and the unconditional jump.
- R5: For bits 2:0 the relations are 000 a>b, 001 a<b, 010 a==b, 011 a!=b, 100 a>=b and 101 a<=b. Both values are signed two's complement. `taken` is only ever 1 together with `is_jump`.
- R6: Codes `0x0E`, `0x0F`, `0x16`, `0x17` and `0x1E` are legal and are not jumps. `0x1E` reports `op_out` = 0 (no-operation). Other legal opcodes report `op_out` equal to the opcode.
- R7: Opcode `0x58` is an unconditional jump. It is always taken, whatever the operands are.
- R8: `next_pc` is the destination field when taken. Otherwise it is `pc + 1`, wrapping modulo 2^16.
- R9: Legal opcodes are `0x00`..`0x2D` except `0x06`, plus `0x40`..`0x44` and `0x58`. Any other opcode sets `illegal` and gives `op_out` = 0, `is_imm` = 0, `is_jump` = 0 and `next_pc` = `pc + 1`.
- R10: `out_valid` equals `in_valid` delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word present this cycle |
| instr | input | 64 | Instruction word |
| src_a | input | 96 | First operand, three 32-bit components |
| src_b | input | 96 | Second operand, three 32-bit components |
| pc | input | 16 | Address of the current instruction |
| out_valid | output | 1 | Registered results are for a presented word |
| op_out | output | 16 | Decoded opcode (0 for no-operation aliases and illegal words) |
| dst_out | output | 16 | Destination / jump target field |
| src1_out | output | 16 | First source address |
| src2_out | output | 16 | Second source address |
| imm_out | output | 32 | Immediate value |
| is_imm | output | 1 | Immediate-form instruction |
| is_jump | output | 1 | Conditional or unconditional jump |
| taken | output | 1 | Jump taken |
| illegal | output | 1 | Unrecognised opcode |
| next_pc | output | 16 | Next program counter |

## Verification
The bench drives negative components against positive ones. A design that compared unsigned would take a greater-than jump that must fall through. It also makes the components differ in the opposite sense from the selected one. A design that decoded bits 4:3 wrongly would then compare the wrong lane and flip the outcome. The non-jump codes that sit inside the jump groups, the debug alias, the hole at `0x06`, a nonzero upper opcode byte, and a fall-through at `pc` = `0xFFFF` are covered. These cases expose a decoder that treats every group code as a jump, lets unknown opcodes through, or fails to wrap the incremented counter.

// File: rtl/vdb_pkg.sv
package vdb_pkg;

  localparam int unsigned TYPE_BIT = 6;

  localparam logic [6:0] OPC_HOLE   = 7'h06;
  localparam logic [6:0] OPC_T1_TOP = 7'h2D;
  localparam logic [6:0] OPC_DBG    = 7'h1E;
  localparam logic [6:0] OPC_T2_TOP = 7'h44;
  localparam logic [6:0] OPC_JUMP   = 7'h58;

  typedef enum logic [2:0] {
    CC_GT = 3'd0,
    CC_LT = 3'd1,
    CC_EQ = 3'd2,
    CC_NE = 3'd3,
    CC_GE = 3'd4,
    CC_LE = 3'd5,
    CC_R6 = 3'd6,
    CC_R7 = 3'd7
  } cond_e;

  typedef struct packed {
    logic       legal;
    logic       imm_form;
    logic       cond_jump;
    logic       uncond;
    logic       nop_alias;
    logic [1:0] comp;
    cond_e      cond;
  } op_class_t;

endpackage

// File: rtl/vdb_field_split.sv
module vdb_field_split #(
  parameter int unsigned OP_W   = 16,
  parameter int unsigned ADDR_W = 16,
  localparam int unsigned INSTR_W = OP_W + 3 * ADDR_W,
  localparam int unsigned IMM_W   = 2 * ADDR_W
) (
  input  logic [INSTR_W-1:0] instr,
  output logic [OP_W-1:0]    op,
  output logic [ADDR_W-1:0]  dst,
  output logic [ADDR_W-1:0]  s1,
  output logic [ADDR_W-1:0]  s2,
  output logic [IMM_W-1:0]   imm
);
  assign op  = instr[INSTR_W-1 -: OP_W];
  assign dst = instr[3*ADDR_W-1 -: ADDR_W];
  assign s1  = instr[2*ADDR_W-1 -: ADDR_W];
  assign s2  = instr[ADDR_W-1:0];
  assign imm = instr[IMM_W-1:0];
endmodule

// File: rtl/vdb_opcode_class.sv
module vdb_opcode_class
  import vdb_pkg::*;
#(
  parameter int unsigned OP_W = 16
) (
  input  logic [OP_W-1:0] op,
  output op_class_t       cls
);
  logic [6:0] low;
  logic       upper_clear;
  logic       t1_ok;
  logic       t2_ok;

  assign low         = op[6:0];
  assign upper_clear = (op[OP_W-1:7] == '0);
  assign t1_ok       = !low[TYPE_BIT] && (low <= OPC_T1_TOP) && (low != OPC_HOLE);
  assign t2_ok       = low[TYPE_BIT] && ((low <= OPC_T2_TOP) || (low == OPC_JUMP));

  always_comb begin
    cls           = '0;
    cls.legal     = upper_clear && (t1_ok || t2_ok);
    cls.imm_form  = cls.legal && low[TYPE_BIT];
    cls.cond_jump = upper_clear && !low[TYPE_BIT] && !low[5] &&
                    (low[4:3] != 2'b00) && (low[2:1] != 2'b11);
    cls.uncond    = upper_clear && (low == OPC_JUMP);
    cls.nop_alias = upper_clear && (low == OPC_DBG);
    cls.comp      = low[4:3];
    cls.cond      = cond_e'(low[2:0]);
  end
endmodule

// File: rtl/vdb_cond_eval.sv
module vdb_cond_eval
  import vdb_pkg::*;
#(
  parameter int unsigned COMP_W = 32,
  parameter int unsigned NCOMP  = 3,
  localparam int unsigned VEC_W = NCOMP * COMP_W
) (
  input  logic [VEC_W-1:0] a,
  input  logic [VEC_W-1:0] b,
  input  logic [1:0]       comp,
  input  cond_e            cond,
  output logic             hit
);
  logic signed [COMP_W-1:0] ca [NCOMP];
  logic signed [COMP_W-1:0] cb [NCOMP];
  logic signed [COMP_W-1:0] xa;
  logic signed [COMP_W-1:0] xb;

  for (genvar g = 0; g < NCOMP; g++) begin : g_lane
    assign ca[g] = a[g*COMP_W +: COMP_W];
    assign cb[g] = b[g*COMP_W +: COMP_W];
  end

  always_comb begin
    xa = '0;
    xb = '0;
    for (int k = 0; k < NCOMP; k++) begin
      if (int'(comp) == k + 1) begin
        xa = ca[k];
        xb = cb[k];
      end
    end
  end

  always_comb begin
    unique case (cond)
      CC_GT:   hit = xa >  xb;
      CC_LT:   hit = xa <  xb;
      CC_EQ:   hit = xa == xb;
      CC_NE:   hit = xa != xb;
      CC_GE:   hit = xa >= xb;
      CC_LE:   hit = xa <= xb;
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/vdb_decode_branch.sv
module vdb_decode_branch
  import vdb_pkg::*;
#(
  parameter int unsigned OP_W   = 16,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned COMP_W = 32,
  parameter int unsigned NCOMP  = 3,
  localparam int unsigned INSTR_W = OP_W + 3 * ADDR_W,
  localparam int unsigned IMM_W   = 2 * ADDR_W,
  localparam int unsigned VEC_W   = NCOMP * COMP_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [INSTR_W-1:0] instr,
  input  logic [VEC_W-1:0]   src_a,
  input  logic [VEC_W-1:0]   src_b,
  input  logic [ADDR_W-1:0]  pc,
  output logic               out_valid,
  output logic [OP_W-1:0]    op_out,
  output logic [ADDR_W-1:0]  dst_out,
  output logic [ADDR_W-1:0]  src1_out,
  output logic [ADDR_W-1:0]  src2_out,
  output logic [IMM_W-1:0]   imm_out,
  output logic               is_imm,
  output logic               is_jump,
  output logic               taken,
  output logic               illegal,
  output logic [ADDR_W-1:0]  next_pc
);
  logic [OP_W-1:0]   f_op;
  logic [ADDR_W-1:0] f_dst;
  logic [ADDR_W-1:0] f_s1;
  logic [ADDR_W-1:0] f_s2;
  logic [IMM_W-1:0]  f_imm;
  op_class_t         cls;
  logic              cmp_hit;

  vdb_field_split #(.OP_W(OP_W), .ADDR_W(ADDR_W)) u_split (
    .instr (instr),
    .op    (f_op),
    .dst   (f_dst),
    .s1    (f_s1),
    .s2    (f_s2),
    .imm   (f_imm)
  );

  vdb_opcode_class #(.OP_W(OP_W)) u_class (
    .op  (f_op),
    .cls (cls)
  );

  vdb_cond_eval #(.COMP_W(COMP_W), .NCOMP(NCOMP)) u_cmp (
    .a    (src_a),
    .b    (src_b),
    .comp (cls.comp),
    .cond (cls.cond),
    .hit  (cmp_hit)
  );

  logic              d_jump;
  logic              d_taken;
  logic [OP_W-1:0]   d_op;
  logic [ADDR_W-1:0] d_s1;
  logic [ADDR_W-1:0] d_s2;
  logic [IMM_W-1:0]  d_imm;
  logic [ADDR_W-1:0] d_next;

  always_comb begin
    d_jump  = cls.legal && (cls.cond_jump || cls.uncond);
    d_taken = cls.legal && (cls.uncond || (cls.cond_jump && cmp_hit));
    d_op    = (cls.legal && !cls.nop_alias) ? f_op : '0;
    d_s1    = (cls.legal && !cls.imm_form) ? f_s1 : '0;
    d_s2    = (cls.legal && !cls.imm_form) ? f_s2 : '0;
    d_imm   = cls.imm_form ? f_imm : '0;
    d_next  = d_taken ? f_dst : pc + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      op_out    <= '0;
      dst_out   <= '0;
      src1_out  <= '0;
      src2_out  <= '0;
      imm_out   <= '0;
      is_imm    <= 1'b0;
      is_jump   <= 1'b0;
      taken     <= 1'b0;
      illegal   <= 1'b0;
      next_pc   <= '0;
    end else begin
      out_valid <= in_valid;
      op_out    <= d_op;
      dst_out   <= f_dst;
      src1_out  <= d_s1;
      src2_out  <= d_s2;
      imm_out   <= d_imm;
      is_imm    <= cls.imm_form;
      is_jump   <= d_jump;
      taken     <= d_taken;
      illegal   <= !cls.legal;
      next_pc   <= d_next;
    end
  end
endmodule

// File: rtl/vdb_decode_branch_chk.sv
module vdb_decode_branch_chk #(
  parameter int unsigned OP_W   = 16,
  parameter int unsigned ADDR_W = 16,
  localparam int unsigned IMM_W = 2 * ADDR_W
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [ADDR_W-1:0] pc,
  input logic              out_valid,
  input logic [OP_W-1:0]   op_out,
  input logic [ADDR_W-1:0] dst_out,
  input logic [ADDR_W-1:0] src1_out,
  input logic [ADDR_W-1:0] src2_out,
  input logic [IMM_W-1:0]  imm_out,
  input logic              is_imm,
  input logic              is_jump,
  input logic              taken,
  input logic              illegal,
  input logic [ADDR_W-1:0] next_pc
);
  AST_TAKEN_IS_JUMP: assert property (@(posedge clk) disable iff (rst)
    taken |-> is_jump); // R5

  AST_IMM_NO_SOURCES: assert property (@(posedge clk) disable iff (rst)
    is_imm |-> (src1_out == '0 && src2_out == '0)); // R2

  AST_REG_NO_IMM: assert property (@(posedge clk) disable iff (rst)
    !is_imm |-> (imm_out == '0)); // R3

  AST_ILLEGAL_AS_NOP: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (op_out == '0 && !is_imm && !is_jump)); // R9

  AST_TAKEN_TARGET: assert property (@(posedge clk) disable iff (rst)
    taken |-> (next_pc == dst_out)); // R8

  AST_FALLTHRU_PC: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (taken || next_pc == $past(pc) + 1'b1)); // R8

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R10

  AST_VALID_FALL: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R10
endmodule

bind vdb_decode_branch vdb_decode_branch_chk #(.OP_W(OP_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .pc        (pc),
  .out_valid (out_valid),
  .op_out    (op_out),
  .dst_out   (dst_out),
  .src1_out  (src1_out),
  .src2_out  (src2_out),
  .imm_out   (imm_out),
  .is_imm    (is_imm),
  .is_jump   (is_jump),
  .taken     (taken),
  .illegal   (illegal),
  .next_pc   (next_pc)
);

// File: tb/sim_vdb_decode_branch.sv
module sim_vdb_decode_branch;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] instr = '0;
  logic [95:0] src_a = '0;
  logic [95:0] src_b = '0;
  logic [15:0] pc = '0;
  logic        out_valid;
  logic [15:0] op_out;
  logic [15:0] dst_out;
  logic [15:0] src1_out;
  logic [15:0] src2_out;
  logic [31:0] imm_out;
  logic        is_imm;
  logic        is_jump;
  logic        taken;
  logic        illegal;
  logic [15:0] next_pc;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  vdb_decode_branch u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
    .src_a(src_a), .src_b(src_b), .pc(pc), .out_valid(out_valid),
    .op_out(op_out), .dst_out(dst_out), .src1_out(src1_out),
    .src2_out(src2_out), .imm_out(imm_out), .is_imm(is_imm),
    .is_jump(is_jump), .taken(taken), .illegal(illegal), .next_pc(next_pc)
  );

  typedef struct packed {
    logic [63:0] ins;
    logic [95:0] a;
    logic [95:0] b;
    logic [15:0] p;
    logic        e_jump;
    logic        e_taken;
    logic        e_ill;
    logic        e_imm;
    logic [15:0] e_next;
    logic [15:0] e_op;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    // JGX 5>3 taken
    {64'h0008_0200_0001_0002, {32'd0, 32'd0, 32'd5}, {32'd0, 32'd0, 32'd3}, 16'h0010, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0200, 16'h0008},
    // JGX -5>3 signed: not taken
    {64'h0008_0200_0001_0002, {32'd0, 32'd0, 32'hFFFF_FFFB}, {32'd0, 32'd0, 32'd3}, 16'h0010, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0011, 16'h0008},
    // JLX -5<3 taken
    {64'h0009_0200_0001_0002, {32'd0, 32'd0, 32'hFFFF_FFFB}, {32'd0, 32'd0, 32'd3}, 16'h0010, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0200, 16'h0009},
    // JEQY y equal, x differs
    {64'h0012_0200_0001_0002, {32'd0, 32'd7, 32'd1}, {32'd0, 32'd7, 32'd2}, 16'h0010, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0200, 16'h0012},
    // JNEY y equal
    {64'h0013_0200_0001_0002, {32'd0, 32'd7, 32'd1}, {32'd0, 32'd7, 32'd2}, 16'h0010, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0011, 16'h0013},
    // JGEZ equal
    {64'h001C_0200_0001_0002, {32'd4, 32'd0, 32'd0}, {32'd4, 32'd0, 32'd0}, 16'h0010, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0200, 16'h001C},
    // JLEZ 5<=4 no
    {64'h001D_0200_0001_0002, {32'd5, 32'd0, 32'd0}, {32'd4, 32'd0, 32'd0}, 16'h0010, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0011, 16'h001D},
    // JGZ z bigger, x,y smaller
    {64'h0018_0200_0001_0002, {32'd9, 32'd0, 32'd0}, {32'd1, 32'd5, 32'd5}, 16'h0010, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0200, 16'h0018},
    // JLY y equal, x smaller
    {64'h0011_0200_0001_0002, {32'd0, 32'd3, 32'd0}, {32'd0, 32'd3, 32'd9}, 16'h0010, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0011, 16'h0011},
    // INC not a jump
    {64'h000E_0200_0001_0002, {32'd0, 32'd0, 32'd5}, {32'd0, 32'd0, 32'd3}, 16'h0010, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0011, 16'h000E},
    // DOT not a jump
    {64'h0017_0200_0001_0002, {32'd0, 32'd9, 32'd0}, {32'd0, 32'd1, 32'd0}, 16'h0010, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0011, 16'h0017},
    // debug alias reads as no-operation
    {64'h001E_0200_0001_0002, {32'd1, 32'd1, 32'd1}, {32'd0, 32'd0, 32'd0}, 16'h0010, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0011, 16'h0000},
    // unconditional jump
    {64'h0058_0200_0000_0000, 96'd0, 96'd0, 16'h0010, 1'b1, 1'b1, 1'b0, 1'b1, 16'h0200, 16'h0058},
    // return: immediate form, not a jump
    {64'h0040_0200_0000_0000, 96'd0, 96'd0, 16'h0010, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0011, 16'h0040},
    // hole 0x06
    {64'h0006_0200_0001_0002, 96'd0, 96'd0, 16'h0010, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0011, 16'h0000},
    // 0x2E past the end
    {64'h002E_0200_0001_0002, 96'd0, 96'd0, 16'h0010, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0011, 16'h0000},
    // 0x45 unknown immediate form
    {64'h0045_0200_0001_0002, 96'd0, 96'd0, 16'h0010, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0011, 16'h0000},
    // upper bits set on a jump code
    {64'h0108_0200_0001_0002, {32'd0, 32'd0, 32'd5}, {32'd0, 32'd0, 32'd3}, 16'h0010, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0011, 16'h0000},
    // JNEX equal at pc wrap
    {64'h000B_0200_0001_0002, {32'd0, 32'd0, 32'd1}, {32'd0, 32'd0, 32'd1}, 16'hFFFF, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h000B},
    // CROSS not a jump
    {64'h0016_0200_0001_0002, {32'd0, 32'd9, 32'd0}, {32'd0, 32'd1, 32'd0}, 16'h0010, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0011, 16'h0016},
    // JGEX -1>=-1
    {64'h000C_0200_0001_0002, {32'd0, 32'd0, 32'hFFFF_FFFF}, {32'd0, 32'd0, 32'hFFFF_FFFF}, 16'h0010, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0200, 16'h000C}
  };

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic present(input logic [63:0] i, input logic [95:0] a, input logic [95:0] b, input logic [15:0] p);
    @(negedge clk);
    in_valid = 1'b1;
    instr = i;
    src_a = a;
    src_b = b;
    pc = p;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "out_valid", {63'd0, out_valid}, 64'd0);
    check("R1", "next_pc", {48'd0, next_pc}, 64'd0);
    check("R1", "op_out", {48'd0, op_out}, 64'd0);
    check("R1", "flags", {60'd0, is_jump, taken, illegal, is_imm}, 64'd0);
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      present(VECS[v].ins, VECS[v].a, VECS[v].b, VECS[v].p);
      check("R4", $sformatf("v%0d is_jump", v), {63'd0, is_jump}, {63'd0, VECS[v].e_jump});
      check("R5", $sformatf("v%0d taken", v), {63'd0, taken}, {63'd0, VECS[v].e_taken});
      check("R9", $sformatf("v%0d illegal", v), {63'd0, illegal}, {63'd0, VECS[v].e_ill});
      check("R3", $sformatf("v%0d is_imm", v), {63'd0, is_imm}, {63'd0, VECS[v].e_imm});
      check("R8", $sformatf("v%0d next_pc", v), {48'd0, next_pc}, {48'd0, VECS[v].e_next});
      check("R6", $sformatf("v%0d op_out", v), {48'd0, op_out}, {48'd0, VECS[v].e_op});
    end

    // R2 register form split
    present(64'h0001_1234_5678_9ABC, 96'd0, 96'd0, 16'h0020);
    check("R2", "dst", {48'd0, dst_out}, 64'h1234);
    check("R2", "src1", {48'd0, src1_out}, 64'h5678);
    check("R2", "src2", {48'd0, src2_out}, 64'h9ABC);
    check("R2", "imm reg form", {32'd0, imm_out}, 64'd0);

    // R2 immediate form split
    present(64'h0041_0777_DEAD_BEEF, 96'd0, 96'd0, 16'h0020);
    check("R2", "imm", {32'd0, imm_out}, 64'hDEAD_BEEF);
    check("R2", "src1 imm form", {48'd0, src1_out}, 64'd0);
    check("R2", "src2 imm form", {48'd0, src2_out}, 64'd0);
    check("R3", "is_imm setx", {63'd0, is_imm}, 64'd1);

    // R7 unconditional jump with arbitrary operands
    present(64'h0058_0ABC_0000_0000, {32'h8000_0000, 32'd3, 32'hFFFF_FFFF}, {32'd7, 32'h7FFF_FFFF, 32'd1}, 16'hFFFF);
    check("R7", "jmp taken", {63'd0, taken}, 64'd1);
    check("R7", "jmp target", {48'd0, next_pc}, 64'h0ABC);

    // R10 valid pipeline
    check("R10", "valid high", {63'd0, out_valid}, 64'd1);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check("R10", "valid low", {63'd0, out_valid}, 64'd0);

    // R1 reset again mid-stream
    present(64'h0008_0200_0001_0002, {32'd0, 32'd0, 32'd5}, {32'd0, 32'd0, 32'd3}, 16'h0010);
    rst = 1'b1;
    @(negedge clk);
    check("R1", "taken after reset", {63'd0, taken}, 64'd0);
    check("R1", "dst after reset", {48'd0, dst_out}, 64'd0);
    rst = 1'b0;
    in_valid = 1'b0;

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule